// File: doc/BRIEF.md
# Clock Period Add/Subtract Fine Tuner

The block divides a fast input clock by four to make a sample clock. The clock runs two input cycles high and two low. It can slide the phase of that sample clock one input period at a time. A stretched output cycle is five input cycles long, which delays the clock. A shrunk output cycle is three input cycles long, which advances it. The high time stays two input cycles in every case.

The direction of each nudge comes from an energy comparison made elsewhere. With each compare strobe the block receives the energy collected in the early half and in the late half of a clocking subinterval. A reversible counter integrates these votes, so the counter width sets how often a correction can happen. A correction is requested only when the counter overflows or reaches zero. All of this is active only while the lock flag is high. Without lock the clock keeps dividing by four and nothing is corrected.

Top module: `clk_phase_trimmer`

## Requirements
- R1: Without corrections `slow_clk_o` has a period of 4 `clk` cycles. While `rst_n` is low it is held high, and after reset the cycle starts with its high phase.
- R2: With `lock_i` high, a cycle with `cmp_stb_i` high steps the vote counter up when `late_nrg_i` > `early_nrg_i` and down when `early_nrg_i` > `late_nrg_i`. Equal energies leave it unchanged, so any number of equal or alternating strobes causes no correction.
- R3: The vote counter (`CNT_W` bits) starts at its midpoint 2^(`CNT_W`-1). A correction needs exactly 2^(`CNT_W`-1) more up-steps than down-steps, in either direction, counted from the midpoint.
- R4: An up-step from the all-ones count (overflow) requests one stretched output period of 5 `clk` cycles.
- R5: A down-step that brings the count to zero requests one shrunk output period of 3 `clk` cycles.
- R6: After a correction is requested the counter reloads to its midpoint, so the next correction again needs the full number of steps.
- R7: While `lock_i` is low, strobes are ignored, the counter is held at its midpoint and any correction not yet applied is dropped.
- R8: A requested correction is applied at the next output period boundary. At most one correction is applied per output period, and a request that arrives while one is still waiting is discarded.
- R9: In every output period, whether stretched, shrunk or plain, `slow_clk_o` is high for exactly 2 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Lock flag; enables tuning when high |
| cmp_stb_i | input | 1 | One-cycle strobe marking valid half energies |
| early_nrg_i | input | EN_W | Energy of the first half of the subinterval |
| late_nrg_i | input | EN_W | Energy of the second half of the subinterval |
| slow_clk_o | output | 1 | Divided sample clock |

## Verification
A strobe changes the counter at the same edge. A resulting correction does not show up at a fixed cycle. It appears as the length of the first output period that starts after the request, so it is due between one and five input cycles later, depending on phase. For that reason the checks do not sample at a fixed offset. A model of the counter queues each expected stretched or shrunk period, and a monitor measures every period between rising edges of the output and pops the queue whenever a period other than four is seen. Strobes are spaced so that the queued corrections have landed before the per-scenario totals are compared.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_ADD  = 2'd1,
    TRIM_SUB  = 2'd2
  } trim_e;

  localparam int unsigned BASE_DIV = 4;
  localparam int unsigned HIGH_LEN = 2;

  // length in input cycles of one output period given the correction
  function automatic logic [2:0] period_len(input trim_e t);
    case (t)
      TRIM_ADD: period_len = 3'(BASE_DIV + 1);
      TRIM_SUB: period_len = 3'(BASE_DIV - 1);
      default:  period_len = 3'(BASE_DIV);
    endcase
  endfunction

endpackage

// File: rtl/ctp_half_vote.sv
module ctp_half_vote #(
  parameter int unsigned EN_W = 16
) (
  input  logic            en,
  input  logic            stb,
  input  logic [EN_W-1:0] early,
  input  logic [EN_W-1:0] late,
  output logic            step_up,
  output logic            step_dn
);

  // +1 late wins, -1 early wins, 0 tie
  function automatic logic [1:0] vote(input logic [EN_W-1:0] e,
                                      input logic [EN_W-1:0] l);
    if (l > e)      vote = 2'b01;
    else if (e > l) vote = 2'b10;
    else            vote = 2'b00;
  endfunction

  logic [1:0] v;

  always_comb begin
    v       = vote(early, late);
    step_up = en && stb && v[0];
    step_dn = en && stb && v[1];
  end

endmodule

// File: rtl/ctp_rate_cnt.sv
module ctp_rate_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic step_up,
  input  logic step_dn,
  output logic req_add,
  output logic req_sub
);

  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic hits_top(input logic [CNT_W-1:0] c, input logic up);
    hits_top = up && (c == TOP);
  endfunction

  function automatic logic hits_zero(input logic [CNT_W-1:0] c, input logic dn);
    hits_zero = dn && (c == CNT_W'(1));
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             reload;

  always_comb begin
    req_add = hits_top(cnt, step_up);
    req_sub = hits_zero(cnt, step_dn);
    reload  = req_add || req_sub;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= MID;
    else if (!en)     cnt <= MID;
    else if (reload)  cnt <= MID;
    else if (step_up) cnt <= cnt + CNT_W'(1);
    else if (step_dn) cnt <= cnt - CNT_W'(1);
  end

  AST_CNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0); // R5
  AST_RELOAD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_add || req_sub) |=> (cnt == MID)); // R6
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_up && !step_dn) |=> $stable(cnt)); // R2
  AST_UNLOCK_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == MID)); // R7
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_add && req_sub)); // R8

endmodule

// File: rtl/ctp_phase_div.sv
module ctp_phase_div
  import ctp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_add,
  input  logic req_sub,
  output logic slow_clk
);

  logic [2:0] ph;
  logic [2:0] ph_nxt;
  logic [2:0] len;
  logic       wrap;
  trim_e      pend;
  trim_e      req_now;
  logic       trim_taken;
  logic       clk_q;

  always_comb begin
    wrap       = (ph == len - 3'd1);
    ph_nxt     = wrap ? 3'd0 : ph + 3'd1;
    req_now    = req_add ? TRIM_ADD : (req_sub ? TRIM_SUB : TRIM_NONE);
    trim_taken = wrap && (pend != TRIM_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 3'd0;
      len   <= 3'(BASE_DIV);
      pend  <= TRIM_NONE;
      clk_q <= 1'b1;
    end else begin
      ph    <= ph_nxt;
      clk_q <= (ph_nxt < 3'(HIGH_LEN));
      if (wrap) begin
        len  <= period_len(pend);
        pend <= en ? req_now : TRIM_NONE;
      end else if (!en) begin
        pend <= TRIM_NONE;
      end else if (pend == TRIM_NONE) begin
        pend <= req_now;
      end
    end
  end

  assign slow_clk = clk_q;

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len >= 3'd3) && (len <= 3'd5)); // R8
  AST_TRIM_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    trim_taken |=> (len != 3'(BASE_DIV))); // R8
  AST_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |=> clk_q); // R9
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend == TRIM_NONE)); // R7
  AST_PLAIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend == TRIM_NONE) |=> (len == 3'(BASE_DIV))); // R1

endmodule

// File: rtl/clk_phase_trimmer.sv
module clk_phase_trimmer #(
  parameter int unsigned EN_W  = 16,
  parameter int unsigned CNT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_i,
  input  logic            cmp_stb_i,
  input  logic [EN_W-1:0] early_nrg_i,
  input  logic [EN_W-1:0] late_nrg_i,
  output logic            slow_clk_o
);

  logic step_up;
  logic step_dn;
  logic req_add;
  logic req_sub;

  ctp_half_vote #(.EN_W(EN_W)) u_vote (
    .en      (lock_i),
    .stb     (cmp_stb_i),
    .early   (early_nrg_i),
    .late    (late_nrg_i),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  ctp_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (lock_i),
    .step_up (step_up),
    .step_dn (step_dn),
    .req_add (req_add),
    .req_sub (req_sub)
  );

  ctp_phase_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (lock_i),
    .req_add  (req_add),
    .req_sub  (req_sub),
    .slow_clk (slow_clk_o)
  );

  AST_NO_STEP_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |-> !(step_up || step_dn)); // R7
  AST_TIE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (early_nrg_i == late_nrg_i) |-> !(step_up || step_dn)); // R2

endmodule

// File: tb/test_clk_phase_trimmer.sv
module test_clk_phase_trimmer;

  localparam int EW = 16;
  localparam int CW = 3;
  localparam int MIDV = 1 << (CW - 1);
  localparam int TOPV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0;
  logic stb = 1'b0;
  logic [EW-1:0] early = '0;
  logic [EW-1:0] late = '0;
  logic slow;

  logic stb2 = 1'b0;
  logic slow2;

  always #2.5 clk = ~clk;

  clk_phase_trimmer #(.EN_W(EW), .CNT_W(CW)) i_clk_phase_trimmer (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .cmp_stb_i(stb),
    .early_nrg_i(early), .late_nrg_i(late), .slow_clk_o(slow));

  clk_phase_trimmer #(.EN_W(EW), .CNT_W(1)) i_clk_phase_trimmer_w1 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .cmp_stb_i(stb2),
    .early_nrg_i(16'd10), .late_nrg_i(16'd20), .slow_clk_o(slow2));

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  int model_cnt = MIDV;
  int exp_add = 0, exp_sub = 0;
  int seen_add = 0, seen_sub = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard model of the vote counter, written from R2..R7
  task automatic model_vote(input int e, input int l);
    if (!lock) begin
      model_cnt = MIDV;
    end else if (l > e) begin
      if (model_cnt == TOPV) begin
        model_cnt = MIDV; exp_q.push_back(5); exp_add++;
      end else model_cnt++;
    end else if (e > l) begin
      if (model_cnt == 1) begin
        model_cnt = MIDV; exp_q.push_back(3); exp_sub++;
      end else model_cnt--;
    end
  endtask

  task automatic strobe(input int e, input int l);
    @(negedge clk);
    early = EW'(e); late = EW'(l); stb = 1'b1;
    model_vote(e, l);
    @(negedge clk);
    stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_lock(input bit v);
    @(negedge clk);
    lock = v;
    if (!v) model_cnt = MIDV;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle_and_compare(input string req);
    repeat (14) @(negedge clk);
    check(seen_add == exp_add, {req, " stretched count"}, seen_add, exp_add);
    check(seen_sub == exp_sub, {req, " shrunk count"}, seen_sub, exp_sub);
  endtask

  // monitor of the main instance
  bit mon_en = 1'b0;
  bit prev = 1'b1;
  bit started = 1'b0;
  int cyc = 0, hi = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (slow && !prev) begin
        if (started) begin
          check(hi == 2, "R9 high time", hi, 2);
          if (cyc == 4) begin
            check(1'b1, "R1 period", cyc, 4);
          end else if (cyc == 5 || cyc == 3) begin
            if (cyc == 5) seen_add++; else seen_sub++;
            if (exp_q.size() == 0) begin
              check(1'b0, (cyc == 5) ? "R4 unexpected stretch" : "R5 unexpected shrink", cyc, 4);
            end else begin
              int e;
              e = exp_q.pop_front();
              check(cyc == e, (e == 5) ? "R4 stretched period" : "R5 shrunk period", cyc, e);
            end
          end else begin
            check(1'b0, "R8 period length", cyc, 4);
          end
        end
        started = 1'b1;
        cyc = 1;
        hi = 1;
      end else begin
        cyc++;
        if (slow) hi++;
      end
      prev = slow;
    end
  end

  // monitor of the one-bit counter instance
  bit mon2_en = 1'b0;
  bit prev2 = 1'b1;
  bit st2 = 1'b0;
  int cyc2 = 0, n5 = 0, nmax = 0, n3 = 0;

  always @(negedge clk) begin
    if (mon2_en) begin
      if (slow2 && !prev2) begin
        if (st2) begin
          if (cyc2 == 5) n5++;
          if (cyc2 == 3) n3++;
          if (cyc2 > nmax) nmax = cyc2;
        end
        st2 = 1'b1;
        cyc2 = 1;
      end else begin
        cyc2++;
      end
      prev2 = slow2;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(slow == 1'b1, "R1 reset level", int'(slow), 1);
    check(slow2 == 1'b1, "R1 reset level w1", int'(slow2), 1);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (20) @(negedge clk);
    lock = 1'b1;
    repeat (4) @(negedge clk);

    // R2: ties never move the counter
    for (int i = 0; i < 20; i++) strobe(100 + i, 100 + i);
    settle_and_compare("R2 equal halves");

    // R3: midpoint needs exactly 2^(CW-1) steps; R4 overflow stretches
    for (int i = 0; i < MIDV - 1; i++) strobe(10, 50);
    settle_and_compare("R3 below threshold");
    strobe(10, 50);
    settle_and_compare("R4 overflow");

    // R6: reload to midpoint after correction
    for (int i = 0; i < MIDV - 1; i++) strobe(10, 50);
    settle_and_compare("R6 reload up");
    strobe(10, 50);
    settle_and_compare("R6 second overflow");

    // R5: early half larger, counter reaches zero
    for (int i = 0; i < MIDV; i++) strobe(900, 3);
    settle_and_compare("R5 zero reached");
    for (int i = 0; i < MIDV - 1; i++) strobe(900, 3);
    settle_and_compare("R6 reload down");
    strobe(900, 3);
    settle_and_compare("R5 second shrink");

    // R2: alternating votes cancel
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 0) strobe(1, 2); else strobe(2, 1);
    end
    settle_and_compare("R2 alternating");

    // R7: no effect without lock, counter held at midpoint
    for (int i = 0; i < MIDV - 1; i++) strobe(10, 50);
    set_lock(1'b0);
    for (int i = 0; i < 10; i++) strobe(10, 50);
    settle_and_compare("R7 strobes unlocked");
    set_lock(1'b1);
    for (int i = 0; i < MIDV - 1; i++) strobe(10, 50);
    settle_and_compare("R7 counter reloaded by unlock");
    strobe(10, 50);
    settle_and_compare("R7 relocked overflow");
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

    // R8: one-bit counter requests every cycle, one stretch per period at most
    mon2_en = 1'b1;
    repeat (10) @(negedge clk);
    stb2 = 1'b1;
    repeat (64) @(negedge clk);
    stb2 = 1'b0;
    repeat (2) @(negedge clk);
    mon2_en = 1'b0;
    check(nmax == 5, "R8 longest period", nmax, 5);
    check(n5 >= 10, "R8 stretched periods under continuous requests", n5, 10);
    check(n3 == 0, "R8 no shrink from up votes", n3, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule